// File: doc/BRIEF.md
# Programmable Priority Group Arbiter

This block selects the winning interrupt among a group of eight already-masked request lines. The ranking is not a per-source level. Software fills eight ordered slots, and each slot names the local source (0 to 7) that occupies that rank. The arbiter walks the slots from rank 0, which is the highest, and the first slot whose source is requesting decides the winner.

A configuration register can hold a single promoted source id. When that source belongs to the group and is requesting, it wins over every slot.

The winner is reported as a 7-bit source id, equal to `ID_BASE` plus the local index. The id is zero when nothing is pending. An interrupt line is raised whenever the id is non-zero. The id follows the requests combinationally. A simple register port gives software access to the slot register and the configuration register, and lets it read the id.

Top module: `prio_group_arb`

## Requirements
- R1: After reset, the slot register reads 0x05309770, so slot p holds source p. The configuration register reads 0, the vector reads 0 and `irq` is low.
- R2: Slot p for p = 0 to 3 is the 3-bit field at bit 20+(3-p)*3 of the slot register. Slot p for p = 4 to 7 is the field at bit 4+(7-p)*3. Only bits 31:20 and 15:4 can be written; bits 19:16 and 3:0 always read zero.
- R3: Without a valid promotion, the winner is the requesting source named by the lowest-numbered slot. The vector then reports `ID_BASE` plus that source's local index.
- R4: A source that no slot names never wins unless it is promoted. When several slots name the same source, the lowest-numbered of them is the one that counts.
- R5: Bits 30:24 of the configuration register hold a promoted source id. If that id lies in `ID_BASE`..`ID_BASE`+7 and that source is requesting, the vector reports it, whatever the slots hold.
- R6: A promoted id outside the group, or one whose source is idle, has no effect on the result.
- R7: With no request pending, the vector is 0. `irq` is high exactly when the vector is non-zero.
- R8: Bit `SPREAD_BIT` of the configuration register is the grouped (0) or spread (1) mode flag. It is stored and reads back, but it does not change the winner. All other configuration bits apart from 30:24 read zero.
- R9: Address 0 selects the slot register and address 1 selects the configuration register. Address 2 returns the vector in bits 6:0 with zeros above it, and address 3 reads zero. Writes to addresses 2 and 3 change nothing, and reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 8 | Masked request per local source |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the selected register |
| vector | output | 7 | Winning source id, 0 when idle |
| irq | output | 1 | Interrupt, high when the vector is non-zero |

## Verification
The assertions assume that `req`, `addr` and `wr_en` are stable when they are sampled at the clock edge. They also assume that `ID_BASE`+7 fits in seven bits and that `ID_BASE` is non-zero, so that the id 0 stays reserved for idle. The bench changes every input on the falling clock edge. It keeps the default base of 32 and only promotes ids that are either inside the group or clearly outside it (0 and 127). This keeps all stimulus within those assumptions.

// File: rtl/prio_group_arb.sv
module prio_group_arb #(
  parameter int ID_BASE    = 32,
  parameter int SPREAD_BIT = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  req,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic [6:0]  vector,
  output logic        irq
);
  localparam int N = 8;
  localparam logic [6:0] BASE7 = 7'(ID_BASE);
  localparam logic [6:0] LAST7 = 7'(ID_BASE + N - 1);
  localparam logic [1:0] A_SLOT = 2'd0, A_CFG = 2'd1, A_VEC = 2'd2;
  localparam logic [31:0] SLOT_WMASK = 32'hFFF0_FFF0;
  localparam logic [31:0] CFG_WMASK  = 32'h7F00_0000 | (32'd1 << SPREAD_BIT);

  function automatic int slot_lsb(input int p);
    return (p < 4) ? 20 + (3 - p) * 3 : 4 + (7 - p) * 3;
  endfunction

  function automatic logic [31:0] identity_map();
    logic [31:0] v = '0;
    for (int p = 0; p < N; p++) v |= 32'(p) << slot_lsb(p);
    return v;
  endfunction

  localparam logic [31:0] SLOT_RESET = identity_map();

  logic [31:0] slot_q, cfg_q;
  logic [2:0]  slot_src [N];
  logic [6:0]  promo_id;
  logic        promo_hit, found;
  logic [2:0]  win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= SLOT_RESET;
      cfg_q  <= '0;
    end else if (wr_en) begin
      if (addr == A_SLOT) slot_q <= wdata & SLOT_WMASK;
      if (addr == A_CFG)  cfg_q  <= wdata & CFG_WMASK;
    end
  end

  for (genvar p = 0; p < N; p++) begin : g_slot
    localparam int LSB = slot_lsb(p);
    assign slot_src[p] = slot_q[LSB +: 3];
  end

  assign promo_id  = cfg_q[30:24];
  assign promo_hit = (promo_id >= BASE7) && (promo_id <= LAST7) &&
                     req[promo_id[2:0] - BASE7[2:0]];

  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int p = 0; p < N; p++) begin
      if (!found && req[slot_src[p]]) begin
        found = 1'b1;
        win   = slot_src[p];
      end
    end
  end

  assign vector = promo_hit ? promo_id : found ? (BASE7 + {4'd0, win}) : 7'd0;
  assign irq    = (vector != 7'd0);

  always_comb begin
    case (addr)
      A_SLOT:  rdata = slot_q;
      A_CFG:   rdata = cfg_q;
      A_VEC:   rdata = {25'd0, vector};
      default: rdata = '0;
    endcase
  end

  AST_IRQ_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (req != 8'd0)); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req == 8'd0) |-> (vector == 7'd0 && !irq)); // R7
  AST_WINNER_REQUESTING: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (vector >= BASE7 && vector <= LAST7 && req[vector[2:0] - BASE7[2:0]])); // R3
  AST_PROMOTED_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[30:24] >= BASE7 && cfg_q[30:24] <= LAST7 && req[cfg_q[26:24] - BASE7[2:0]])
    |-> (vector == cfg_q[30:24])); // R5
  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_SLOT) |=> $stable(slot_q)); // R2
  AST_VEC_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_VEC) |-> (rdata == {25'd0, vector})); // R9
endmodule

// File: tb/prio_group_arb_test.sv
module prio_group_arb_test;
  localparam int BASE = 32;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  req = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [6:0]  vector;
  logic        irq;
  int total = 0, failed = 0;

  always #4 clk = ~clk;

  prio_group_arb uut (.clk(clk), .rst_n(rst_n), .req(req), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .vector(vector), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int lsb_of(input int p);
    return (p < 4) ? 29 - 3 * p : 25 - 3 * p;
  endfunction

  function automatic logic [6:0] model(input logic [31:0] slots, input logic [31:0] cfg,
                                       input logic [7:0] r);
    int pid = int'(cfg[30:24]);
    if (pid >= BASE && pid < BASE + 8 && r[pid - BASE]) return 7'(pid);
    for (int p = 0; p < 8; p++) begin
      int s = int'((slots >> lsb_of(p)) & 32'd7);
      if (r[s]) return 7'(BASE + s);
    end
    return 7'd0;
  endfunction

  task automatic sweep(input string tag, input logic [31:0] slots, input logic [31:0] cfg);
    for (int r = 0; r < 256; r++) begin
      @(negedge clk);
      req = 8'(r); addr = 2'd2;
      #1;
      chk(tag, {25'd0, vector}, {25'd0, model(slots, cfg, 8'(r))});
      chk({tag, " irq R7"}, {31'd0, irq}, {31'd0, model(slots, cfg, 8'(r)) != 7'd0});
      chk({tag, " read R9"}, rdata, {25'd0, model(slots, cfg, 8'(r))});
    end
    req = '0;
  endtask

  function automatic logic [31:0] pack(input int m [8]);
    logic [31:0] v = '0;
    for (int p = 0; p < 8; p++) v |= 32'(m[p]) << lsb_of(p);
    return v;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failed++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    int rev [8];
    int dup [8];
    logic [31:0] rev_v, dup_v, id_v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int p = 0; p < 8; p++) rev[p] = 7 - p;
    for (int p = 0; p < 8; p++) dup[p] = 3;
    dup[5] = 6; dup[7] = 1;
    id_v = 32'd0;
    for (int p = 0; p < 8; p++) id_v |= 32'(p) << lsb_of(p);
    rev_v = pack(rev); dup_v = pack(dup);

    addr = 2'd0; #1; chk("R1 slot reset", rdata, 32'h0530_9770);
    chk("R1 identity", rdata, id_v);
    addr = 2'd1; #1; chk("R1 cfg reset", rdata, 32'd0);
    chk("R1 vector", {25'd0, vector}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    sweep("R3 identity", id_v, 32'd0);

    wr(2'd0, 32'hFFFF_FFFF);
    addr = 2'd0; #1; chk("R2 write mask", rdata, 32'hFFF0_FFF0);
    wr(2'd0, rev_v);
    addr = 2'd0; #1; chk("R2 readback", rdata, rev_v);
    sweep("R2 R3 reversed", rev_v, 32'd0);

    wr(2'd0, dup_v);
    sweep("R4 duplicates", dup_v, 32'd0);
    @(negedge clk); req = 8'b1011_0101; #1;
    chk("R4 unnamed never wins", {25'd0, vector}, 32'd0);

    for (int s = 0; s < 8; s++) begin
      wr(2'd1, 32'(BASE + s) << 24);
      sweep("R5 promoted", dup_v, 32'(BASE + s) << 24);
    end
    wr(2'd1, 32'd0 << 24);
    sweep("R6 promote id 0", dup_v, 32'd0);
    wr(2'd1, 32'd127 << 24);
    sweep("R6 promote id 127", dup_v, 32'd127 << 24);

    wr(2'd1, 32'hFFFF_FFFF);
    addr = 2'd1; #1; chk("R8 cfg mask", rdata, 32'hFF00_0001 & 32'h7F00_0001);
    wr(2'd1, 32'h0000_0001);
    addr = 2'd1; #1; chk("R8 spread stored", rdata, 32'h0000_0001);
    sweep("R8 spread no effect", dup_v, 32'h0000_0001);

    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd3, 32'hFFFF_FFFF);
    addr = 2'd0; #1; chk("R9 slot untouched", rdata, dup_v);
    addr = 2'd1; #1; chk("R9 cfg untouched", rdata, 32'h0000_0001);
    addr = 2'd3; #1; chk("R9 addr3 zero", rdata, 32'd0);
    @(negedge clk); req = 8'b0000_1000; addr = 2'd2;
    repeat (3) @(negedge clk);
    chk("R9 repeated read", rdata, 32'(BASE + 3));
    chk("R9 no side effect", {25'd0, vector}, 32'(BASE + 3));

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule